// File: doc/BRIEF.md
# Fixed Segment Address Translator

This block turns a 32-bit virtual address into a physical address for a processor core that has no translation lookaside buffer and no page tables. The address space is cut into four fixed segments. One of them is open to unprivileged code, and the other three are kernel-only. Each segment has a fixed relocation rule and a fixed cacheability attribute. The core presents an address with a valid strobe, its current privilege level and a flag that says whether the access is an instruction fetch. One clock later the block returns the physical address, the cacheability attribute and a valid strobe, or an address-error flag instead.

Kernel code reaches the low 512 MB of physical memory through two aliased windows: a cached window for normal use and an uncached window for boot code and I/O registers. The unprivileged segment is moved up by 1 GB. This leaves one 512 MB physical range that no translation can produce, which a system can use as a guard region. The top megabyte of the unprivileged segment and the top megabyte of the address space are held back for later use. Here they translate exactly like the segment around them and never fault.

Top module: `seg_xlate_top`

## Requirements
- R1: A virtual address below 0x80000000 is translated by adding 0x40000000, giving a physical address from 0x40000000 to 0xBFFFFFFF, and is marked cached (rsp_cached=1).
- R2: A virtual address with bits [31:29]=3'b100 is translated by clearing bits [31:29], and is marked cached.
- R3: A virtual address with bits [31:29]=3'b101 is translated by clearing bits [31:29], and is marked uncached (rsp_cached=0).
- R4: A virtual address at or above 0xC0000000 passes through unchanged and is marked cached.
- R5: The reserved megabytes 0x7FF00000–0x7FFFFFFF and 0xFFF00000–0xFFFFFFFF translate by their parent segment's rule and raise no error in any mode that may use that segment.
- R6: A valid result never has a physical address in 0x20000000–0x3FFFFFFF, that is, bits [31:29] are never 3'b001.
- R7: A request made in user mode (req_kmode=0) with bit 31 set gives rsp_aerr=1 and rsp_vld=0 in the next cycle, and rsp_paddr and rsp_cached keep their previous values. A request made in kernel mode never raises rsp_aerr.
- R8: The result of a request appears one clock after the request. A cycle with req_vld=0 gives rsp_vld=0 and rsp_aerr=0 in the next cycle, and rsp_paddr and rsp_cached keep their values.
- R9: While reset is asserted, rsp_vld and rsp_aerr are 0. Reset asserts asynchronously and is released on a clock edge.
- R10: req_ifetch has no effect on the translation, the attribute or the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| req_vld | input | 1 | A translation request is present this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kmode | input | 1 | 1 = kernel privilege, 0 = user privilege |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| rsp_vld | output | 1 | Registered translation result is valid |
| rsp_paddr | output | 32 | Registered physical address |
| rsp_cached | output | 1 | 1 = cacheable, 0 = uncached |
| rsp_aerr | output | 1 | Address error: user-mode access to a kernel segment |

## Verification
The hardest case to reach from the ports is the hold behaviour after a refused request. After a user-mode request to a kernel address, the physical address and attribute must still show the last good translation, so the outputs only reveal the hold if a known good result came just before the fault. The stimulus therefore walks every segment and reserved-region edge in both privilege modes and with both fetch settings. It puts faulting user requests directly after good ones and runs idle cycles between groups. A reference model in the bench predicts every output on every clock.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    SEG_USER    = 2'd0,
    SEG_KLOW_C  = 2'd1,
    SEG_KLOW_U  = 2'd2,
    SEG_KHIGH   = 2'd3
  } seg_e;

  typedef struct packed {
    seg_e seg;
    logic rsvd;
  } seg_info_t;
endpackage

// File: rtl/seg_classify.sv
module seg_classify
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RSV_LSB = 20
) (
  input  logic [ADDR_W-1:0] vaddr,
  output seg_info_t         info
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    info.rsvd = &vaddr[TOP-1:RSV_LSB];
    if (!vaddr[TOP])
      info.seg = SEG_USER;
    else if (vaddr[TOP-1])
      info.seg = SEG_KHIGH;
    else if (vaddr[TOP-2])
      info.seg = SEG_KLOW_U;
    else
      info.seg = SEG_KLOW_C;
  end
endmodule

// File: rtl/seg_remap.sv
module seg_remap
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 29
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  seg_info_t         info,
  output logic [ADDR_W-1:0] paddr,
  output logic              cached
);
  localparam logic [ADDR_W-1:0] USER_OFS = ADDR_W'(1) << (ADDR_W - 2);

  always_comb begin
    case (info.seg)
      SEG_USER: begin
        paddr  = vaddr + USER_OFS;
        cached = 1'b1;
      end
      SEG_KLOW_C: begin
        paddr  = {{(ADDR_W-WIN_W){1'b0}}, vaddr[WIN_W-1:0]};
        cached = 1'b1;
      end
      SEG_KLOW_U: begin
        paddr  = {{(ADDR_W-WIN_W){1'b0}}, vaddr[WIN_W-1:0]};
        cached = 1'b0;
      end
      default: begin
        paddr  = vaddr;
        cached = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_xlate_pkg::*;
(
  input  seg_info_t info,
  input  logic      kmode,
  output logic      deny
);
  always_comb deny = !kmode && (info.seg != SEG_USER);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_W   = 29,
  parameter int RSV_LSB = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_kmode,
  input  logic              req_ifetch,
  output logic              rsp_vld,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_cached,
  output logic              rsp_aerr
);
  localparam int HOLE_W = ADDR_W - WIN_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  seg_info_t         info;
  logic [ADDR_W-1:0] map_paddr;
  logic              map_cached;
  logic              deny;

  seg_classify #(.ADDR_W(ADDR_W), .RSV_LSB(RSV_LSB)) u_class (
    .vaddr (req_vaddr),
    .info  (info)
  );

  seg_remap #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_map (
    .vaddr  (req_vaddr),
    .info   (info),
    .paddr  (map_paddr),
    .cached (map_cached)
  );

  seg_guard u_guard (
    .info  (info),
    .kmode (req_kmode),
    .deny  (deny)
  );

  // fetch and data accesses share one translation path
  logic unused_ifetch;
  assign unused_ifetch = req_ifetch;

  // next state
  logic vld_d, aerr_d, load_en;
  always_comb begin
    load_en = req_vld && !deny;
    vld_d   = load_en;
    aerr_d  = req_vld && deny;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_vld  <= 1'b0;
      rsp_aerr <= 1'b0;
    end else begin
      rsp_vld  <= vld_d;
      rsp_aerr <= aerr_d;
    end
  end

  // data registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (load_en) begin
      rsp_paddr  <= map_paddr;
      rsp_cached <= map_cached;
    end
  end

  // ---------------- assertions ----------------
  assert_user_fault_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && !req_kmode && req_vaddr[ADDR_W-1]) |=> (rsp_aerr && !rsp_vld));

  assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_aerr |-> ($stable(rsp_paddr) && $stable(rsp_cached)));

  assert_kernel_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && req_kmode) |=> !rsp_aerr);

  assert_no_hole_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_vld |-> (rsp_paddr[ADDR_W-1 -: HOLE_W] != HOLE_W'(1)));

  assert_uncached_win_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && req_kmode && req_vaddr[ADDR_W-1 -: 3] == 3'b101)
      |=> (rsp_vld && !rsp_cached && rsp_paddr[ADDR_W-1 -: HOLE_W] == '0));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_vld |=> (!rsp_vld && !rsp_aerr));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(rsp_vld && rsp_aerr));

  assert_rsvd_ok_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && info.rsvd && (req_kmode || !req_vaddr[ADDR_W-1])) |=> (rsp_vld && !rsp_aerr));
endmodule

// File: tb/tb_seg_xlate_top.sv
module tb_seg_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_kmode, req_ifetch;
  logic [31:0] req_vaddr;
  logic        rsp_vld, rsp_cached, rsp_aerr;
  logic [31:0] rsp_paddr;

  int vectors = 0;
  int misses  = 0;

  // reference state
  logic        e_vld, e_aerr, e_cached, have_data;
  logic [31:0] e_paddr;
  string       e_tag;

  always #5 clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_vaddr(req_vaddr),
    .req_kmode(req_kmode), .req_ifetch(req_ifetch), .rsp_vld(rsp_vld),
    .rsp_paddr(rsp_paddr), .rsp_cached(rsp_cached), .rsp_aerr(rsp_aerr)
  );

  function automatic void ref_map(input logic [31:0] va, output logic [31:0] pa, output logic c);
    longint unsigned a = longint'(va);
    if (a < 64'h8000_0000) begin pa = 32'(a + 64'h4000_0000); c = 1'b1; end
    else if (a < 64'hA000_0000) begin pa = 32'(a - 64'h8000_0000); c = 1'b1; end
    else if (a < 64'hC000_0000) begin pa = 32'(a - 64'hA000_0000); c = 1'b0; end
    else begin pa = va; c = 1'b1; end
  endfunction

  function automatic string seg_tag(input logic [31:0] va);
    if (va >= 32'h7FF0_0000 && va <= 32'h7FFF_FFFF) return "R5";
    if (va >= 32'hFFF0_0000) return "R5";
    if (!va[31]) return "R1";
    if (va[31:29] == 3'b100) return "R2";
    if (va[31:29] == 3'b101) return "R3";
    return "R4";
  endfunction

  task automatic chk1(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare all outputs against the reference (called between edges)
  task automatic compare();
    chk1(e_tag, "rsp_vld", 32'(rsp_vld), 32'(e_vld));
    chk1(e_tag, "rsp_aerr", 32'(rsp_aerr), 32'(e_aerr));
    if (have_data) begin
      chk1(e_tag, "rsp_paddr", rsp_paddr, e_paddr);
      chk1(e_tag, "rsp_cached", 32'(rsp_cached), 32'(e_cached));
    end
    if (rsp_vld)
      chk1("R6", "paddr_hole", 32'(rsp_paddr[31:29] == 3'b001), 32'd0);
  endtask

  // apply one request at a negedge, update the reference
  task automatic step(input logic v, input logic [31:0] va, input logic k, input logic f);
    logic [31:0] pa;
    logic c;
    req_vld = v; req_vaddr = va; req_kmode = k; req_ifetch = f;
    if (!v) begin
      e_vld = 1'b0; e_aerr = 1'b0; e_tag = "R8";
    end else if (!k && va[31]) begin
      e_vld = 1'b0; e_aerr = 1'b1; e_tag = "R7";
    end else begin
      ref_map(va, pa, c);
      e_vld = 1'b1; e_aerr = 1'b0; e_paddr = pa; e_cached = c; have_data = 1'b1;
      e_tag = f ? "R10" : seg_tag(va);
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #1_000_000;
    misses++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] edges [12];
    edges = '{32'h0000_0000, 32'h7FEF_FFFF, 32'h7FF0_0000, 32'h7FFF_FFFF,
              32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF,
              32'hC000_0000, 32'hFFEF_FFFF, 32'hFFF0_0000, 32'hFFFF_FFFF};
    have_data = 1'b0;
    rst_n = 1'b0;
    req_vld = 1'b1; req_vaddr = 32'h8000_1000; req_kmode = 1'b1; req_ifetch = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset holds the strobes low despite a pending request
    chk1("R9", "rsp_vld in reset", 32'(rsp_vld), 32'd0);
    chk1("R9", "rsp_aerr in reset", 32'(rsp_aerr), 32'd0);
    req_vld = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    e_vld = 1'b0; e_aerr = 1'b0; e_tag = "R9";
    compare();

    // every boundary, both modes, both access kinds; faults after good results
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 2; f++)
        for (int i = 0; i < 12; i++) begin
          step(1'b1, edges[i], 1'(m), 1'(f));
          step(1'b1, edges[11 - i], 1'(~m), 1'(f));
        end

    // idle cycles hold data (R8)
    step(1'b1, 32'h1234_5678, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    // user fault right after uncached kernel result: attribute held (R7)
    step(1'b1, 32'hA000_0040, 1'b1, 1'b0);
    step(1'b1, 32'h8000_0000, 1'b0, 1'b0);
    step(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1);
    step(1'b0, 32'h0, 1'b1, 1'b0);

    // same address as fetch and as data (R10)
    step(1'b1, 32'hB000_0100, 1'b1, 1'b1);
    step(1'b1, 32'hB000_0100, 1'b1, 1'b0);

    // scattered traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 3) != 0), $urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule